// File: doc/BRIEF.md
# Post-Correction Output Transfer Controller

This block sits between a two-stage block decoder and a host processor. The decoder first corrects each block along its rows, then corrects a whole frame along its columns. Each block reaches this controller with a two-bit outcome code. The controller decides which row-corrected block, and which column-corrected block, goes into each hand-over. It requests the transfer on an active-low line and holds a readout deadline. If the deadline passes, the controller frees the buffer for the next block whether or not the host has finished.

For each frame the controller decides whether column correction should run. It tells the decoder which blocks must stay untouched by the column pass. Once the pass finishes, it walks the column-corrected blocks upwards from block 1. Two configuration inputs control what is offered. The first relaxes the default output filter. The second forces column output for frames that were never column corrected. The timing reference is a one-cycle pulse each millisecond.

Top module: `pcx_xfer_ctrl`

## Requirements
- R1: A cycle with `blk_valid` that offers at least one block pulls `int_n` low from the next cycle. In that same cycle `row_ofr`/`row_num` and `col_ofr`/`col_num` describe the blocks offered. A hand-over carries at most one block of each kind.
- R2: Outcome codes are 00 error-free, 01 fully fixed by row correction, 10 left uncorrectable and 11 parity. The row stream offers codes 00 and 01. It offers code 10 only while `cfg_int_move` is 1. It never offers code 11.
- R3: The readout window is 9 ms when a column block is offered and 18 ms for a row-only hand-over. On the window-th `tick_ms` after the request, `int_n` returns high and `ovr_flag` is set.
- R4: A `rd_done` pulse while `int_n` is low returns `int_n` high on the next edge and leaves `ovr_flag` unchanged. This holds even in the same cycle as the final window tick.
- R5: A new hand-over arriving while `int_n` is low replaces the offer, keeps `int_n` low, restarts the window and sets `ovr_flag`. `ovr_flag` is sticky until `ovr_clr`, and a set wins over a clear in the same cycle.
- R6: `col_run` pulses in the cycle after `frame_done` only under three conditions. All NBLK blocks have arrived since `frame_start`. `in_sync` stayed high through the frame. At least one block carried code 10.
- R7: From the cycle after `frame_done`, bit i of `col_protect` is 1 exactly when block i+1 of that frame carried code 00 or 01.
- R8: After a frame whose column pass ran, `col_done` starts the column stream. Each later hand-over takes the next eligible block in ascending order from block 1, one per hand-over.
- R9: The column stream never offers code-11 blocks. It skips code-01 blocks unless `cfg_int_move` is 1. When no eligible block is left, `col_ofr` stays 0.
- R10: For a frame whose column pass did not run, the column stream starts at `frame_done` only when `cfg_vec_out` is 1. Otherwise that frame yields no column output.
- R11: After reset, no column block is offered until a frame has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| in_sync | input | 1 | Frame synchronisation held |
| frame_start | input | 1 | First block of a frame follows |
| frame_done | input | 1 | Last block of the frame has arrived |
| blk_valid | input | 1 | Row-corrected block ready |
| blk_num | input | NUM_W | Block number, 1..NBLK |
| blk_stat | input | 2 | Outcome code of the block |
| col_done | input | 1 | Column pass has finished |
| rd_done | input | 1 | Host has read the offered blocks |
| ovr_clr | input | 1 | Clears the overrun flag |
| cfg_int_move | input | 1 | Relaxes the default output filter |
| cfg_vec_out | input | 1 | Forces column output for frames without a column pass |
| int_n | output | 1 | Active-low transfer request |
| row_ofr | output | 1 | Hand-over carries a row block |
| row_num | output | NUM_W | Number of the row block |
| col_ofr | output | 1 | Hand-over carries a column block |
| col_num | output | NUM_W | Number of the column block |
| ovr_flag | output | 1 | Sticky window-overrun flag |
| col_run | output | 1 | Column pass requested for this frame |
| col_protect | output | NBLK | Blocks the column pass must not alter |

## Verification
Window expiry can fall in the same cycle as either a host `rd_done` or a fresh hand-over. The bench counts a row-only window down to its last millisecond. On that final tick it raises `rd_done` in one run and `blk_valid` in another. In the first case `int_n` must be high and `ovr_flag` must stay clear. In the second case `int_n` must stay low with a new offer, and `ovr_flag` must be set.

// File: rtl/pcx_pkg.sv
// Shared outcome codes for the post-correction transfer controller.
package pcx_pkg;
    typedef enum logic [1:0] {
        BS_CLEAN  = 2'b00,
        BS_ROWFIX = 2'b01,
        BS_UNCORR = 2'b10,
        BS_PARITY = 2'b11
    } blk_stat_e;
endpackage

// File: rtl/pcx_frame_track.sv
// Tracks one frame of block outcomes and decides whether the column pass runs.
// At frame end it snapshots the outcomes for the column stream and builds the
// protect mask. Assumes frame_done never coincides with blk_valid.
module pcx_frame_track
    import pcx_pkg::*;
#(
    parameter int NBLK  = 16,
    parameter int NUM_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sync,
    input  logic              frame_start,
    input  logic              frame_done,
    input  logic              blk_valid,
    input  logic [NUM_W-1:0]  blk_num,
    input  logic [1:0]        blk_stat,
    input  logic              col_done,
    input  logic              vec_out,
    output logic              col_run,
    output logic              col_start,
    output logic [NBLK-1:0]   col_protect,
    output logic [2*NBLK-1:0] col_tab
);
    logic [1:0]       row_tab [NBLK];
    logic [NUM_W-1:0] rx_cnt;
    logic             in_frame, lost, any_unc, run_pend;
    logic             run_now;

    assign run_now = (rx_cnt == NUM_W'(NBLK)) && !lost && any_unc;

    // Record each block's outcome in the live table.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NBLK; i++) begin
            if (!rst_n)
                row_tab[i] <= BS_PARITY;
            else if (blk_valid && blk_num == NUM_W'(i + 1))
                row_tab[i] <= blk_stat;
        end
    end

    // Frame bookkeeping: arrivals, sync loss and uncorrectable presence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cnt   <= '0;
            in_frame <= 1'b0;
            lost     <= 1'b0;
            any_unc  <= 1'b0;
        end else if (frame_start) begin
            rx_cnt   <= '0;
            in_frame <= 1'b1;
            lost     <= !in_sync;
            any_unc  <= 1'b0;
        end else begin
            if (blk_valid && rx_cnt != '1)
                rx_cnt <= rx_cnt + 1'b1;
            if (in_frame && !in_sync)
                lost <= 1'b1;
            if (blk_valid && blk_stat == BS_UNCORR)
                any_unc <= 1'b1;
            if (frame_done)
                in_frame <= 1'b0;
        end
    end

    // Frame-end decision, snapshot, protect mask and column stream start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_run     <= 1'b0;
            col_start   <= 1'b0;
            run_pend    <= 1'b0;
            col_protect <= '0;
            col_tab     <= '1;
        end else begin
            col_run   <= frame_done && run_now;
            col_start <= (frame_done && !run_now && vec_out) || (col_done && run_pend);
            if (frame_done && run_now)
                run_pend <= 1'b1;
            else if (col_done)
                run_pend <= 1'b0;
            if (frame_done) begin
                for (int i = 0; i < NBLK; i++) begin
                    col_tab[2*i +: 2] <= row_tab[i];
                    col_protect[i]    <= (row_tab[i] == BS_CLEAN) || (row_tab[i] == BS_ROWFIX);
                end
            end
        end
    end

    // The column pass is requested only after a fully received frame.
    assert_run_full_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        col_run |-> ($past(rx_cnt) == NUM_W'(NBLK) && !$past(lost)));
endmodule

// File: rtl/pcx_col_seq.sv
// Walks the column-corrected snapshot in ascending order and offers one eligible
// block per hand-over. Assumes col_start never coincides with take_req.
module pcx_col_seq
    import pcx_pkg::*;
#(
    parameter int NBLK  = 16,
    parameter int NUM_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              col_start,
    input  logic              take_req,
    input  logic              int_move,
    input  logic [2*NBLK-1:0] col_tab,
    output logic              col_avail,
    output logic [NUM_W-1:0]  col_num
);
    logic             active, found;
    logic [NUM_W-1:0] ptr, idx;

    // Find the first eligible block at or above the pointer.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NBLK; i++) begin
            if (!found && NUM_W'(i) >= ptr &&
                col_tab[2*i +: 2] != BS_PARITY &&
                (col_tab[2*i +: 2] != BS_ROWFIX || int_move)) begin
                found = 1'b1;
                idx   = NUM_W'(i);
            end
        end
    end

    assign col_avail = active && found;
    assign col_num   = idx + 1'b1;

    // Advance the pointer on each hand-over; stop when nothing is left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ptr    <= '0;
        end else if (col_start) begin
            active <= 1'b1;
            ptr    <= '0;
        end else if (active && take_req) begin
            if (found)
                ptr <= idx + 1'b1;
            else
                active <= 1'b0;
        end
    end

    // A parity block is never offered.
    assert_no_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
        col_avail |-> col_tab[2*idx +: 2] != BS_PARITY);
endmodule

// File: rtl/pcx_req_timer.sv
// Holds the current offer, drives the active-low request and times the readout
// window with the millisecond tick. It also keeps the sticky overrun flag.
// Assumes at most one tick per window cycle boundary.
module pcx_req_timer #(
    parameter int WIN_SHORT = 9,
    parameter int WIN_LONG  = 18,
    parameter int NUM_W     = 5,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic             rd_done,
    input  logic             ovr_clr,
    input  logic             row_take,
    input  logic             col_take,
    input  logic [NUM_W-1:0] row_num_in,
    input  logic [NUM_W-1:0] col_num_in,
    output logic             int_n,
    output logic             row_ofr,
    output logic             col_ofr,
    output logic [NUM_W-1:0] row_num,
    output logic [NUM_W-1:0] col_num,
    output logic             ovr_flag
);
    logic             req, pending, last_tick;
    logic [CNT_W-1:0] cnt, limit;

    assign req       = row_take || col_take;
    assign pending   = !int_n;
    assign limit     = col_ofr ? CNT_W'(WIN_SHORT) : CNT_W'(WIN_LONG);
    assign last_tick = pending && tick_ms && (cnt == limit - CNT_W'(1));

    // Load a new offer, release on read-done, or release at window expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_n   <= 1'b1;
            row_ofr <= 1'b0;
            col_ofr <= 1'b0;
            row_num <= '0;
            col_num <= '0;
            cnt     <= '0;
        end else if (req) begin
            int_n   <= 1'b0;
            row_ofr <= row_take;
            col_ofr <= col_take;
            row_num <= row_num_in;
            col_num <= col_num_in;
            cnt     <= '0;
        end else if (pending && rd_done) begin
            int_n <= 1'b1;
        end else if (last_tick) begin
            int_n <= 1'b1;
        end else if (pending && tick_ms) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Sticky overrun: overwrite of a pending offer or unanswered expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_flag <= 1'b0;
        else if ((req && pending) || (!req && !rd_done && last_tick))
            ovr_flag <= 1'b1;
        else if (ovr_clr)
            ovr_flag <= 1'b0;
    end

    assert_int_low_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !int_n);
    assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> cnt < limit);
    assert_rd_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n && rd_done && !req) |=> (int_n && $stable(ovr_flag) || ovr_clr));
    assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);
endmodule

// File: rtl/pcx_xfer_ctrl.sv
// Top of the post-correction transfer controller. It applies the row-stream
// filter, joins the frame tracker, column sequencer and request timer, and
// exposes the hand-over to the host. Assumes block numbers run 1..NBLK.
module pcx_xfer_ctrl
    import pcx_pkg::*;
#(
    parameter int NBLK      = 16,
    parameter int WIN_SHORT = 9,
    parameter int WIN_LONG  = 18,
    parameter int NUM_W     = $clog2(NBLK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic             in_sync,
    input  logic             frame_start,
    input  logic             frame_done,
    input  logic             blk_valid,
    input  logic [NUM_W-1:0] blk_num,
    input  logic [1:0]       blk_stat,
    input  logic             col_done,
    input  logic             rd_done,
    input  logic             ovr_clr,
    input  logic             cfg_int_move,
    input  logic             cfg_vec_out,
    output logic             int_n,
    output logic             row_ofr,
    output logic [NUM_W-1:0] row_num,
    output logic             col_ofr,
    output logic [NUM_W-1:0] col_num,
    output logic             ovr_flag,
    output logic             col_run,
    output logic [NBLK-1:0]  col_protect
);
    localparam int CNT_W = $clog2(WIN_LONG + 1);

    logic [2*NBLK-1:0] col_tab;
    logic              col_start, col_avail, row_take, col_take;
    logic [NUM_W-1:0]  seq_num;

    // Row stream filter: parity never, uncorrectable only when relaxed.
    assign row_take = blk_valid && blk_stat != BS_PARITY &&
                      (blk_stat != BS_UNCORR || cfg_int_move);
    assign col_take = blk_valid && col_avail;

    pcx_frame_track #(.NBLK(NBLK), .NUM_W(NUM_W)) u_track (
        .clk(clk), .rst_n(rst_n), .in_sync(in_sync),
        .frame_start(frame_start), .frame_done(frame_done),
        .blk_valid(blk_valid), .blk_num(blk_num), .blk_stat(blk_stat),
        .col_done(col_done), .vec_out(cfg_vec_out),
        .col_run(col_run), .col_start(col_start),
        .col_protect(col_protect), .col_tab(col_tab)
    );

    pcx_col_seq #(.NBLK(NBLK), .NUM_W(NUM_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .col_start(col_start),
        .take_req(blk_valid), .int_move(cfg_int_move), .col_tab(col_tab),
        .col_avail(col_avail), .col_num(seq_num)
    );

    pcx_req_timer #(.WIN_SHORT(WIN_SHORT), .WIN_LONG(WIN_LONG),
                    .NUM_W(NUM_W), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .rd_done(rd_done),
        .ovr_clr(ovr_clr), .row_take(row_take), .col_take(col_take),
        .row_num_in(blk_num), .col_num_in(seq_num),
        .int_n(int_n), .row_ofr(row_ofr), .col_ofr(col_ofr),
        .row_num(row_num), .col_num(col_num), .ovr_flag(ovr_flag)
    );
endmodule

// File: tb/pcx_xfer_ctrl_bench.sv
module pcx_xfer_ctrl_bench;
    localparam int NBLK = 16;
    localparam int NUM_W = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick_ms = 0, in_sync = 0, frame_start = 0, frame_done = 0, blk_valid = 0;
    logic [NUM_W-1:0] blk_num = '0;
    logic [1:0] blk_stat = '0;
    logic col_done = 0, rd_done = 0, ovr_clr = 0, cfg_int_move = 0, cfg_vec_out = 0;
    logic int_n, row_ofr, col_ofr, ovr_flag, col_run;
    logic [NUM_W-1:0] row_num, col_num;
    logic [NBLK-1:0] col_protect;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    pcx_xfer_ctrl u_pcx_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .in_sync(in_sync),
        .frame_start(frame_start), .frame_done(frame_done), .blk_valid(blk_valid),
        .blk_num(blk_num), .blk_stat(blk_stat), .col_done(col_done),
        .rd_done(rd_done), .ovr_clr(ovr_clr), .cfg_int_move(cfg_int_move),
        .cfg_vec_out(cfg_vec_out), .int_n(int_n), .row_ofr(row_ofr),
        .row_num(row_num), .col_ofr(col_ofr), .col_num(col_num),
        .ovr_flag(ovr_flag), .col_run(col_run), .col_protect(col_protect)
    );

    // Row filter vectors: {stat, int_move, expect_offer}
    localparam logic [3:0] ROW_VEC [8] = '{
        4'b00_0_1, 4'b00_1_1, 4'b01_0_1, 4'b01_1_1,
        4'b10_0_0, 4'b10_1_1, 4'b11_0_0, 4'b11_1_0
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_rd();
        rd_done = 1; @(negedge clk); rd_done = 0;
    endtask
    task automatic pulse_clr();
        ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    endtask
    task automatic tick();
        tick_ms = 1; @(negedge clk); tick_ms = 0; @(negedge clk);
    endtask
    task automatic send_blk(input int n, input logic [1:0] s);
        blk_valid = 1; blk_num = NUM_W'(n); blk_stat = s;
        @(negedge clk); blk_valid = 0;
    endtask
    task automatic pulse_done();
        col_done = 1; @(negedge clk); col_done = 0; @(negedge clk);
    endtask
    // Send a whole frame; drop sync during block 8 when asked.
    task automatic send_frame(input logic [2*NBLK-1:0] stats, input bit drop);
        frame_start = 1; @(negedge clk); frame_start = 0;
        for (int n = 1; n <= NBLK; n++) begin
            if (drop && n == 8) begin in_sync = 0; @(negedge clk); in_sync = 1; end
            send_blk(n, stats[2*(n-1) +: 2]);
        end
        pulse_rd(); pulse_clr();
        frame_done = 1; @(negedge clk); frame_done = 0;
    endtask

    initial begin
        #(1_000_000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [2*NBLK-1:0] mix, clean;
        mix = '0;
        mix[2*1 +: 2] = 2'b01; mix[2*2 +: 2] = 2'b10; mix[2*4 +: 2] = 2'b01;
        mix[2*14 +: 2] = 2'b11; mix[2*15 +: 2] = 2'b11;
        clean = '0;
        in_sync = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1 reset int_n", int_n, 1);
        check("R5 reset ovr", ovr_flag, 0);
        check("R6 reset col_run", col_run, 0);

        // R11: forced column output set, but no frame completed yet
        cfg_vec_out = 1;
        send_blk(7, 2'b00);
        check("R11 no col before frame", col_ofr, 0);
        check("R1 row_num", row_num, 7);
        pulse_rd();
        cfg_vec_out = 0;

        // R2 table walk
        foreach (ROW_VEC[k]) begin
            cfg_int_move = ROW_VEC[k][1];
            send_blk(k + 1, ROW_VEC[k][3:2]);
            check("R2 row filter int_n", int_n, !ROW_VEC[k][0]);
            if (ROW_VEC[k][0]) check("R2 row_ofr", row_ofr, 1);
            pulse_rd();
            check("R4 release", int_n, 1);
        end
        cfg_int_move = 0;
        check("R4 no ovr", ovr_flag, 0);

        // R3 row-only 18 ms window
        send_blk(2, 2'b00);
        for (int t = 0; t < 17; t++) tick();
        check("R3 held at 17ms", int_n, 0);
        tick();
        check("R3 expire 18ms", int_n, 1);
        check("R3 ovr on expiry", ovr_flag, 1);
        pulse_clr();
        check("R5 ovr cleared", ovr_flag, 0);

        // R5 overwrite while pending
        send_blk(3, 2'b00);
        send_blk(4, 2'b01);
        check("R5 overwrite ovr", ovr_flag, 1);
        check("R5 new offer", row_num, 4);
        check("R5 int low", int_n, 0);
        pulse_rd(); pulse_clr();

        // Coincidence: rd_done on the final tick
        send_blk(5, 2'b00);
        for (int t = 0; t < 17; t++) tick();
        rd_done = 1; tick_ms = 1; @(negedge clk); rd_done = 0; tick_ms = 0;
        check("R4 rd wins int_n", int_n, 1);
        check("R4 rd wins ovr", ovr_flag, 0);
        // Coincidence: new hand-over on the final tick
        send_blk(5, 2'b00);
        for (int t = 0; t < 17; t++) tick();
        tick_ms = 1; send_blk(6, 2'b00); tick_ms = 0;
        check("R5 req wins int_n", int_n, 0);
        check("R5 req wins ovr", ovr_flag, 1);
        check("R5 req wins num", row_num, 6);
        pulse_rd(); pulse_clr();

        // Frame with uncorrectable block, full sync
        send_frame(mix, 0);
        check("R6 col_run", col_run, 1);
        check("R7 protect", col_protect, 16'h3FFB);
        pulse_done();
        send_blk(1, 2'b00);
        check("R8 first col", col_num, 1);
        check("R8 col_ofr", col_ofr, 1);
        for (int t = 0; t < 8; t++) tick();
        check("R3 held at 8ms", int_n, 0);
        tick();
        check("R3 expire 9ms", int_n, 1);
        pulse_clr();
        send_blk(1, 2'b00);
        check("R9 skip rowfix", col_num, 3);
        pulse_rd();
        send_blk(1, 2'b00);
        check("R8 ascending", col_num, 4);
        pulse_rd();
        cfg_int_move = 1;
        send_blk(1, 2'b00);
        check("R9 rowfix with int_move", col_num, 5);
        pulse_rd();
        cfg_int_move = 0;
        for (int n = 6; n <= 14; n++) begin
            send_blk(1, 2'b00);
            check("R8 walk", col_num, n);
            pulse_rd();
        end
        send_blk(1, 2'b00);
        check("R9 parity never", col_ofr, 0);
        pulse_rd(); pulse_clr();

        // R6 sync lost
        send_frame(mix, 1);
        check("R6 sync lost", col_run, 0);
        pulse_done();
        // R6/R10 clean frame, default: no column output
        send_frame(clean, 0);
        check("R6 clean frame", col_run, 0);
        @(negedge clk);
        send_blk(1, 2'b00);
        check("R10 default none", col_ofr, 0);
        pulse_rd();
        // R10 forced
        cfg_vec_out = 1;
        send_frame(clean, 0);
        @(negedge clk);
        send_blk(1, 2'b00);
        check("R10 forced col", col_ofr, 1);
        check("R10 forced num", col_num, 1);
        pulse_rd();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule